// File: doc/BRIEF.md
# Conversion-Ready Status Collector with Open-Drain Indicator

This block gathers single-cycle ready strobes from eight conversion sources into one status byte. A read strobe empties the whole byte in one step. Each source has its own bit, so software can tell which results are new since the last read.

The block also drives one open-drain indicator pin through a pull-low enable. The pin is never driven high. A two-bit mode field in an 8-bit configuration register sets how the pin behaves:

- **Plain output:** the pin follows an output bit.
- **Short pulse:** the pin pulls low for a fixed short time on every ready event.
- **Long pulse:** the pin pulls low for a fixed long time on every ready event.
- **Hold:** the pin pulls low from a ready event until the status byte is read.

A ready event is the OR of all eight strobes. Both pulse widths are derived from a clock-frequency parameter: 16 µs and 128 µs of clock cycles.

The pin is controlled by a state machine with these states:

- `ST_GPIO`: plain output.
- `ST_WAIT`: pin released, waiting for an event.
- `ST_PULSE`: timed low pulse.
- `ST_HOLD`: latched low.

It has these transitions:

- *event-start*: `ST_WAIT` → `ST_PULSE`, or `ST_WAIT` → `ST_HOLD`, on a ready event.
- *retrigger*: `ST_PULSE` → `ST_PULSE` on an event, which reloads the count.
- *expire*: `ST_PULSE` → `ST_WAIT` when the count reaches zero.
- *read-release*: `ST_HOLD` → `ST_WAIT` on a status read with no event in the same cycle.
- *mode-switch*: any state → `ST_GPIO` or `ST_WAIT`, one cycle after the mode field changes.

Top module: `drdy_indicator`

## Requirements
- R1: Strobe input bit i sets status bit i at the next clock edge, and the bit then stays set until a read. The bit order from bit 7 down to bit 0 is: current converters, voltage converter, GPIO4, GPIO3, GPIO2, GPIO1, SENSE2 and SENSE1.
- R2: A status read with no strobe active clears every status bit at that edge.
- R3: When a strobe and a status read occur in the same cycle, the byte after that edge equals the strobe pattern. Events are applied after the clear.
- R4: After reset the status byte is 0x00, the configuration register is 0x03, and the pin pulls low.
- R5: In mode 00 (register bits [5:4]) the pull-low enable equals register bit 0, and ready events have no effect on the pin.
- R6: In mode 01 each event pulls the pin low for exactly SHORT cycles, starting the cycle after the event. SHORT is 16 µs of clock.
- R7: In mode 10 each event pulls the pin low for exactly LONG cycles, starting the cycle after the event. LONG is 128 µs of clock.
- R8: An event during a pulse restarts the full width, counted from that latest event.
- R9: In mode 11 an event pulls the pin low from the next cycle. A read with no event in the same cycle releases the pin at that edge. A read together with an event keeps the pin low.
- R10: A configuration write loads the byte at the clock edge. The output bit is bit 0, the alert polarity bit is bit 1 (reset value 1 = active high), and the mode field is bits [5:4].
- R11: A strobe on any one of the eight inputs alone counts as a ready event for the pin.
- R12: One cycle after the mode field changes, the pin machine drops any pulse or hold and restarts in the plain-output or waiting state. An event that arrives on that cycle does not start a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ready | input | 8 | Ready strobes, one per source, in status-bit order |
| status_rd | input | 1 | Status read strobe; clears the byte at the edge |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| status_q | output | 8 | Clear-on-read status byte |
| cfg_q | output | 8 | Configuration register contents |
| pin_pull_low | output | 1 | Open-drain pull-low enable for the indicator pin |

## Verification
The assertions take for granted that the configuration changes only through the write port. Their pulse, hold and width properties apply only when the mode field has been steady for one cycle and no write lands on the event edge. During a mode switch the pin legitimately keeps its old behaviour for one cycle, so the properties exclude that window. The random stimulus keeps configuration writes rare (about one per several hundred cycles), so most events fall in steady-mode windows. Directed sequences cover the switch window on purpose.

// File: rtl/drdy_pkg.sv
`timescale 1ns/1ps
package drdy_pkg;

    // Pin machine states
    typedef enum logic [1:0] {
        ST_GPIO  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } pin_state_e;

    // Mode field encodings
    localparam logic [1:0] MODE_GPO   = 2'b00;
    localparam logic [1:0] MODE_SHORT = 2'b01;
    localparam logic [1:0] MODE_LONG  = 2'b10;
    localparam logic [1:0] MODE_HOLD  = 2'b11;

    // Configuration field positions
    localparam int CFG_OUT_BIT  = 0;
    localparam int CFG_POL_BIT  = 1;
    localparam int CFG_MODE_LSB = 4;
    localparam logic [7:0] CFG_RESET = 8'h03;

    // Pulse width in clock cycles for a clock in kHz and a width in microseconds
    function automatic int pulse_cycles(input int clk_khz, input int width_us);
        return (clk_khz * width_us) / 1000;
    endfunction

endpackage

// File: rtl/drdy_status_reg.sv
`timescale 1ns/1ps
module drdy_status_reg #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_ready,
    input  logic             status_rd,
    output logic [N_SRC-1:0] status_q
);

    // One sticky bit per source: the read clears first, then a new strobe sets
    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[gi] <= 1'b0;
            end else begin
                status_q[gi] <= (status_q[gi] & ~status_rd) | src_ready[gi];
            end
        end
    end

endmodule

// File: rtl/drdy_cfg_reg.sv
`timescale 1ns/1ps
module drdy_cfg_reg #(
    parameter int          WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

endmodule

// File: rtl/drdy_pin_fsm.sv
`timescale 1ns/1ps
module drdy_pin_fsm
    import drdy_pkg::*;
#(
    parameter int SHORT_CYC = 16,
    parameter int LONG_CYC  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic       status_rd,
    input  logic [1:0] mode,
    input  logic       gp_low,
    output logic       pin_pull_low
);

    localparam int CNT_W = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYC - 1);

    pin_state_e       state, state_n;
    logic [1:0]       mode_q;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] reload;

    assign reload = (mode == MODE_LONG) ? LONG_M1 : SHORT_M1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_GPIO;
            mode_q <= MODE_GPO;
            cnt    <= '0;
        end else begin
            state  <= state_n;
            mode_q <= mode;
            cnt    <= cnt_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (mode != mode_q) begin
            // mode-switch
            state_n = (mode == MODE_GPO) ? ST_GPIO : ST_WAIT;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_GPIO: begin
                    if (mode != MODE_GPO) begin
                        state_n = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (evt) begin
                        // event-start
                        if (mode == MODE_HOLD) begin
                            state_n = ST_HOLD;
                        end else if (mode != MODE_GPO) begin
                            state_n = ST_PULSE;
                            cnt_n   = reload;
                        end
                    end
                end
                ST_PULSE: begin
                    if (evt) begin
                        cnt_n = reload;          // retrigger
                    end else if (cnt == '0) begin
                        state_n = ST_WAIT;       // expire
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (status_rd && !evt) begin
                        state_n = ST_WAIT;       // read-release
                    end
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        if (mode == MODE_GPO) begin
            pin_pull_low = gp_low;
        end else begin
            pin_pull_low = (state == ST_PULSE) || (state == ST_HOLD);
        end
    end

endmodule

// File: rtl/drdy_indicator.sv
`timescale 1ns/1ps
module drdy_indicator
    import drdy_pkg::*;
#(
    parameter int CLK_KHZ = 200000,
    parameter int N_SRC   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_ready,
    input  logic             status_rd,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [N_SRC-1:0] status_q,
    output logic [7:0]       cfg_q,
    output logic             pin_pull_low
);

    localparam int SHORT_CYC = pulse_cycles(CLK_KHZ, 16);
    localparam int LONG_CYC  = pulse_cycles(CLK_KHZ, 128);

    logic       any_evt;
    logic [1:0] pin_mode;

    assign any_evt  = |src_ready;
    assign pin_mode = cfg_q[CFG_MODE_LSB +: 2];

    drdy_status_reg #(
        .N_SRC (N_SRC)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_ready (src_ready),
        .status_rd (status_rd),
        .status_q  (status_q)
    );

    drdy_cfg_reg #(
        .WIDTH     (8),
        .RESET_VAL (CFG_RESET)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .q       (cfg_q)
    );

    drdy_pin_fsm #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (any_evt),
        .status_rd    (status_rd),
        .mode         (pin_mode),
        .gp_low       (cfg_q[CFG_OUT_BIT]),
        .pin_pull_low (pin_pull_low)
    );

endmodule

// File: rtl/drdy_indicator_chk.sv
`timescale 1ns/1ps
module drdy_indicator_chk
    import drdy_pkg::*;
#(
    parameter int CLK_KHZ = 200000,
    parameter int N_SRC   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_ready,
    input logic             status_rd,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic [N_SRC-1:0] status_q,
    input logic [7:0]       cfg_q,
    input logic             pin_pull_low
);

    localparam int SHORT_CYC = pulse_cycles(CLK_KHZ, 16);
    localparam int LONG_CYC  = pulse_cycles(CLK_KHZ, 128);
    localparam int SW        = $clog2(LONG_CYC + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic [1:0]    mode;
    logic          steady;
    logic [SW-1:0] since_evt;

    assign mode   = cfg_q[CFG_MODE_LSB +: 2];
    assign steady = !cfg_we || (cfg_wdata == cfg_q);

    // Cycles since the last ready event, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_evt <= SMAX;
        end else if (|src_ready) begin
            since_evt <= SW'(1);
        end else if (since_evt != SMAX) begin
            since_evt <= since_evt + 1'b1;
        end
    end

    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_ready) |=> ((status_q & $past(src_ready)) == $past(src_ready)));

    p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_rd && src_ready == '0) |=> (status_q == $past(status_q)));

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && src_ready == '0) |=> (status_q == '0));

    p_rd_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && |src_ready) |=> (status_q == $past(src_ready)));

    p_gp_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_GPO) |-> (pin_pull_low == cfg_q[CFG_OUT_BIT]));

    p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SHORT || mode == MODE_LONG) && $stable(cfg_q) && steady && |src_ready)
        |=> pin_pull_low);

    p_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pull_low && $stable(cfg_q) && (mode == MODE_SHORT || mode == MODE_LONG))
        |-> (int'(since_evt) <= ((mode == MODE_LONG) ? LONG_CYC : SHORT_CYC)));

    p_hold_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && $stable(cfg_q) && steady && |src_ready) |=> pin_pull_low);

    p_hold_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && $stable(cfg_q) && steady && status_rd && src_ready == '0)
        |=> !pin_pull_low);

    p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_wdata)));

endmodule

bind drdy_indicator drdy_indicator_chk #(
    .CLK_KHZ (CLK_KHZ),
    .N_SRC   (N_SRC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_ready    (src_ready),
    .status_rd    (status_rd),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .status_q     (status_q),
    .cfg_q        (cfg_q),
    .pin_pull_low (pin_pull_low)
);

// File: tb/drdy_indicator_tb.sv
`timescale 1ns/1ps
module drdy_indicator_tb;

    localparam int CLK_KHZ = 1000;
    localparam int SHORT   = 16;
    localparam int LONG    = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_ready = '0;
    logic       status_rd = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] status_q;
    logic [7:0] cfg_q;
    logic       pin_pull_low;

    always #2.5 clk = ~clk;

    drdy_indicator #(.CLK_KHZ(CLK_KHZ), .N_SRC(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .status_rd(status_rd),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .status_q(status_q),
        .cfg_q(cfg_q), .pin_pull_low(pin_pull_low)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] m_status = '0;
    logic [7:0] m_cfg = 8'h03;
    logic [1:0] m_prev = 2'b00;
    int         m_rem = 0;
    bit         m_hold = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    function automatic int width_of(input logic [1:0] m);
        return (m == 2'b10) ? LONG : SHORT;
    endfunction

    function automatic logic exp_pin();
        if (m_cfg[5:4] == 2'b00) return m_cfg[0];
        return (m_rem > 0) || m_hold;
    endfunction

    task automatic model(input logic [7:0] s, input logic r, input logic we, input logic [7:0] wd);
        logic [1:0] md;
        md = m_cfg[5:4];
        if (md != m_prev) begin
            m_rem = 0;                       // R12 restart on mode change
            m_hold = 0;
        end else begin
            case (md)
                2'b01, 2'b10: begin
                    if (|s) m_rem = width_of(md);
                    else if (m_rem > 0) m_rem--;
                end
                2'b11: begin
                    if (|s) m_hold = 1;
                    else if (r) m_hold = 0;
                end
                default: ;
            endcase
        end
        m_prev = md;
        m_status = (r ? 8'h00 : m_status) | s;
        if (we) m_cfg = wd;
    endtask

    task automatic step(input logic [7:0] s, input logic r, input logic we, input logic [7:0] wd);
        string pt, st;
        src_ready = s; status_rd = r; cfg_we = we; cfg_wdata = wd;
        @(posedge clk);
        model(s, r, we, wd);
        #1;
        st = (r && |s) ? "R3" : (r ? "R2" : "R1");
        case (m_cfg[5:4])
            2'b00:   pt = "R5";
            2'b01:   pt = "R6";
            2'b10:   pt = "R7";
            default: pt = "R9";
        endcase
        chk(st, 32'(status_q), 32'(m_status));
        chk("R10", 32'(cfg_q), 32'(m_cfg));
        chk(pt, 32'(pin_pull_low), 32'(exp_pin()));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(8'h00, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic wcfg(input logic [7:0] v);
        step(8'h00, 1'b0, 1'b1, v);
        idle(2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all R): actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R4 reset state
        chk("R4", 32'(status_q), 32'h00);
        chk("R4", 32'(cfg_q), 32'h03);
        chk("R4", 32'(pin_pull_low), 32'h1);

        // R5: output bit drives pin, events ignored
        wcfg(8'h02);
        chk("R5", 32'(pin_pull_low), 32'h0);
        step(8'hFF, 1'b0, 1'b0, 8'h00);
        chk("R5", 32'(pin_pull_low), 32'h0);
        step(8'h00, 1'b1, 1'b0, 8'h00);

        // R11: each single source triggers a short pulse
        wcfg(8'h10);
        for (int i = 0; i < 8; i++) begin
            step(8'(1 << i), 1'b0, 1'b0, 8'h00);
            chk("R11", 32'(pin_pull_low), 32'h1);
            chk("R1", 32'(status_q[i]), 32'h1);
            idle(SHORT + 2);
            chk("R11", 32'(pin_pull_low), 32'h0);
            step(8'h00, 1'b1, 1'b0, 8'h00);
        end

        // R8: retrigger extends from latest event
        step(8'h01, 1'b0, 1'b0, 8'h00);
        idle(10);
        step(8'h02, 1'b0, 1'b0, 8'h00);
        idle(SHORT - 1);
        chk("R8", 32'(pin_pull_low), 32'h1);
        idle(1);
        chk("R8", 32'(pin_pull_low), 32'h0);

        // R12: mode change mid pulse releases the pin
        wcfg(8'h20);
        step(8'h80, 1'b0, 1'b0, 8'h00);
        idle(3);
        step(8'h00, 1'b0, 1'b1, 8'h30);
        chk("R12", 32'(pin_pull_low), 32'h1);
        step(8'h40, 1'b0, 1'b0, 8'h00);
        chk("R12", 32'(pin_pull_low), 32'h0);

        // R3 / R9 in hold mode
        idle(1);
        step(8'h04, 1'b0, 1'b0, 8'h00);
        chk("R9", 32'(pin_pull_low), 32'h1);
        step(8'h01, 1'b1, 1'b0, 8'h00);
        chk("R3", 32'(status_q), 32'h01);
        chk("R9", 32'(pin_pull_low), 32'h1);
        step(8'h00, 1'b1, 1'b0, 8'h00);
        chk("R9", 32'(pin_pull_low), 32'h0);
        chk("R2", 32'(status_q), 32'h00);

        // Constrained random in each mode
        for (int md = 0; md < 4; md++) begin
            rv = $urandom;
            wcfg({rv[7:6], 2'(md), rv[3:0]});
            for (int n = 0; n < 3000; n++) begin
                logic [7:0] s;
                logic r, we;
                logic [7:0] wd;
                rv = $urandom;
                s  = (rv[4:0] == 5'd0) ? 8'($urandom) : 8'h00;
                r  = (rv[9:6] == 4'd0);
                we = (rv[19:10] == 10'd0);
                wd = 8'($urandom);
                step(s, r, we, wd);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule